// File: doc/BRIEF.md
# Dual-Mode PWM Audio DAC with Half-Step Symmetric Output

This block turns a stream of audio sample words into a single pulse-width-modulated pin. The period is fixed at 512 system clocks, about 31.3 kHz from a 16 MHz clock. An external analog filter recovers the audio from the pin. At the start of each period the block raises a one-cycle update strobe. The sample source answers it with a new word and a valid strobe.

Two output shapes are selectable. In edge mode the pin stays low for the first part of the period and goes high for the last part. This gives 9-bit resolution with one reload point per period. In symmetric mode a counter runs up through half the period and back down. A plain up/down compare here would give only 8 bits. Instead the block uses different compare thresholds on the rising and falling halves, so an odd level puts its extra clock into one half. The high pulse stays centred and the full 9-bit resolution is kept. The result is the same as comparing the level against a triangle that steps through the even values on the way up and the odd values on the way down.

Samples are double-buffered. A new word takes effect only at the next period boundary, so no period mixes two samples. The mode select is latched at the same boundary. Level zero holds the pin low and full scale holds it high in both modes.

Top module: `sympwm_dac`

## Requirements
- R1: The period is exactly 512 clocks. `upd_o` is high for exactly one cycle, the first cycle (position 0) of every period.
- R2: In edge mode (`mode_i` = 0), a period with level L is low for 512-L clocks and then high for L clocks.
- R3: In symmetric mode (`mode_i` = 1), with T = 512-L, a period is low for ceil(T/2) clocks, then high for L clocks, then low for floor(T/2) clocks. Equivalently, at position p the pin is high when tri(p) >= T, where tri(p) = 2p for p < 256 and tri(p) = 2(511-p)+1 otherwise.
- R4: `smp_i` is an unsigned 10-bit level. Values above 512 are treated as 512. Level 0 gives a constant low pin and level 512 gives a constant high pin in both modes, with no pulse at period boundaries.
- R5: A word accepted with `smp_vld_i` high in the middle of a period does not change the current period. It governs the next period.
- R6: A word accepted in the last cycle of a period (position 511) governs the period that starts on the next cycle.
- R7: `mode_i` is sampled only in the last cycle of a period. Changing it mid-period does not change the shape of the current period.
- R8: When several words are accepted within one period, the last one governs the next period. Without a new word, the previous level repeats.
- R9: After reset, the block is at position 0 with `upd_o` high, edge mode, level 0, and the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 10 | Sample level, unsigned, saturated at 512 |
| smp_vld_i | input | 1 | Accept `smp_i` on this clock edge |
| mode_i | input | 1 | Output shape: 0 edge, 1 symmetric |
| pwm_o | output | 1 | PWM output pin |
| upd_o | output | 1 | High in the first cycle of each period |

## Verification
The conflict of interest is a sample strobe that lands in the same cycle as the period wrap. In that cycle the pending buffer and the active level both load. The word must bypass straight into the period that starts next, and it must not be lost or delayed by one period. The bench provokes this by strobing at position 511 and comparing every pin cycle of the following period against the triangle model. It uses the same cycle-by-cycle comparison for a mode flip and for two strobes inside one period, to show that only the wrap cycle moves state into the active period.

// File: rtl/sympwm_pkg.sv
package sympwm_pkg;
   typedef enum logic {
      PWM_EDGE = 1'b0,
      PWM_SYM  = 1'b1
   } pwm_mode_e;
endpackage

// File: rtl/sympwm_timebase.sv
module sympwm_timebase
   import sympwm_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  pwm_mode_e        mode_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             dwn_o,
   output logic             bottom_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             dwn_q, dwn_d;
   logic             top_hit, zero_hit;

   assign top_hit  = (cnt_q == {CNT_W{1'b1}});
   assign zero_hit = (cnt_q == '0);
   assign wrap_o   = dwn_q && ((mode_i == PWM_SYM) ? zero_hit : top_hit);
   assign bottom_o = !dwn_q && zero_hit;

   always_comb begin
      cnt_d = cnt_q;
      dwn_d = dwn_q;
      if (wrap_o) begin
         cnt_d = '0;
         dwn_d = 1'b0;
      end else if (!dwn_q) begin
         if (top_hit) begin
            dwn_d = 1'b1;
            if (mode_i == PWM_EDGE) cnt_d = '0;
         end else begin
            cnt_d = cnt_q + 1'b1;
         end
      end else if (mode_i == PWM_SYM) begin
         cnt_d = cnt_q - 1'b1;
      end else begin
         cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         dwn_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         dwn_q <= dwn_d;
      end
   end

   assign cnt_o = cnt_q;
   assign dwn_o = dwn_q;

   // R1: the period ends by returning to the bottom position
   assert_wrap_to_bottom_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |=> bottom_o);
   // R1: bottom is a single cycle per period
   assert_bottom_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bottom_o |=> !bottom_o);
endmodule

// File: rtl/sympwm_smpbuf.sv
module sympwm_smpbuf
   import sympwm_pkg::*;
#(
   parameter int CNT_W = 8,
   localparam int SMP_W = CNT_W + 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SMP_W-1:0] smp_i,
   input  logic             vld_i,
   input  pwm_mode_e        mode_i,
   input  logic             wrap_i,
   output logic [SMP_W-1:0] lvl_o,
   output pwm_mode_e        mode_o
);
   localparam logic [SMP_W-1:0] FULL = SMP_W'(2 ** (CNT_W + 1));

   logic [SMP_W-1:0] sat, pend_q, act_q;
   pwm_mode_e        mode_q;

   assign sat = (smp_i > FULL) ? FULL : smp_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= '0;
         act_q  <= '0;
         mode_q <= PWM_EDGE;
      end else begin
         if (vld_i) pend_q <= sat;
         if (wrap_i) begin
            act_q  <= vld_i ? sat : pend_q;
            mode_q <= mode_i;
         end
      end
   end

   assign lvl_o  = act_q;
   assign mode_o = mode_q;

   // R5: the active level changes only across a period wrap
   assert_lvl_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(wrap_i) |-> $stable(act_q));
   // R7: the active mode changes only across a period wrap
   assert_mode_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(wrap_i) |-> $stable(mode_q));
   // R4: the active level never exceeds full scale
   assert_lvl_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_q <= FULL);
endmodule

// File: rtl/sympwm_cmp.sv
module sympwm_cmp
   import sympwm_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter bit SYM_EN = 1'b1,
   localparam int SMP_W = CNT_W + 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             dwn_i,
   input  logic             bottom_i,
   input  logic [SMP_W-1:0] lvl_i,
   input  pwm_mode_e        mode_i,
   output logic             pwm_o
);
   localparam logic [SMP_W-1:0] FULL = SMP_W'(2 ** (CNT_W + 1));

   logic [SMP_W-1:0] thr;
   logic             edge_hi;

   assign thr     = FULL - lvl_i;
   assign edge_hi = {1'b0, dwn_i, cnt_i} >= thr;

   if (SYM_EN) begin : g_sym
      logic [SMP_W-1:0] thr_up, thr_dn;
      logic             sym_hi;
      assign thr_up = (thr + 1'b1) >> 1;
      assign thr_dn = thr >> 1;
      assign sym_hi = dwn_i ? ({2'b00, cnt_i} >= thr_dn)
                            : ({2'b00, cnt_i} >= thr_up);
      assign pwm_o  = (mode_i == PWM_SYM) ? sym_hi : edge_hi;

      // R3: the symmetric pulse is centred, low at the bottom unless full scale
      assert_sym_bottom_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (mode_i == PWM_SYM && bottom_i && lvl_i != FULL) |-> !pwm_o);
      // R3: the symmetric pulse covers the turnaround for any non-zero level
      assert_sym_peak_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (mode_i == PWM_SYM && dwn_i && cnt_i == {CNT_W{1'b1}} && lvl_i != '0) |-> pwm_o);
   end else begin : g_edge_only
      assign pwm_o = edge_hi;
   end

   // R4: level zero gives constant low
   assert_zero_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_i == '0) |-> !pwm_o);
   // R4: full scale gives constant high
   assert_full_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_i == FULL) |-> pwm_o);
endmodule

// File: rtl/sympwm_dac.sv
module sympwm_dac
   import sympwm_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter bit SYM_EN = 1'b1,
   localparam int SMP_W = CNT_W + 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SMP_W-1:0] smp_i,
   input  logic             smp_vld_i,
   input  logic             mode_i,
   output logic             pwm_o,
   output logic             upd_o
);
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
      $error("sympwm_dac: CNT_W must lie in 2..16");
   end

   logic [CNT_W-1:0] cnt;
   logic             dwn, bottom, wrap;
   logic [SMP_W-1:0] lvl;
   pwm_mode_e        act_mode, eff_mode, req_mode;

   assign req_mode = pwm_mode_e'(mode_i);

   if (SYM_EN) begin : g_mode_sym
      assign eff_mode = act_mode;
   end else begin : g_mode_edge
      assign eff_mode = PWM_EDGE;
   end

   sympwm_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (eff_mode),
      .cnt_o    (cnt),
      .dwn_o    (dwn),
      .bottom_o (bottom),
      .wrap_o   (wrap)
   );

   sympwm_smpbuf #(.CNT_W(CNT_W)) u_buf (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .smp_i  (smp_i),
      .vld_i  (smp_vld_i),
      .mode_i (req_mode),
      .wrap_i (wrap),
      .lvl_o  (lvl),
      .mode_o (act_mode)
   );

   sympwm_cmp #(.CNT_W(CNT_W), .SYM_EN(SYM_EN)) u_cmp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cnt_i    (cnt),
      .dwn_i    (dwn),
      .bottom_i (bottom),
      .lvl_i    (lvl),
      .mode_i   (eff_mode),
      .pwm_o    (pwm_o)
   );

   assign upd_o = bottom;
endmodule

// File: tb/sympwm_dac_tb.sv
module sympwm_dac_tb;
   localparam int CLK_P = 10;
   localparam int CNT_W = 8;
   localparam int P     = 2 ** (CNT_W + 1);
   localparam int H     = P / 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] smp = '0;
   logic       vld = 1'b0;
   logic       mode = 1'b0;
   logic       pwm, upd;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model of the block state
   int cur_m = 0, cur_l = 0, pend_l = 0;

   always #(CLK_P / 2) clk = ~clk;

   sympwm_dac #(.CNT_W(CNT_W)) u_dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .smp_i     (smp),
      .smp_vld_i (vld),
      .mode_i    (mode),
      .pwm_o     (pwm),
      .upd_o     (upd)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic bit exp_bit(int m, int l, int p);
      int lc, t, tri_v;
      lc = (l > P) ? P : l;
      t  = P - lc;
      if (m == 0) return p >= t;
      tri_v = (p < H) ? 2 * p : 2 * (P - 1 - p) + 1;
      return tri_v >= t;
   endfunction

   task automatic check(string tag, bit ok, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One period, starting at position 0, checked cycle by cycle against the model.
   // Optional strobes at positions pa/pb (va/vb < 0: no strobe); mode_i set to nm at pa.
   task automatic run_period(string tag, int pa, int va, int pb, int vb, int nm);
      int bad = 0, first = -1, fa = 0, fe = 0;
      check({tag, " period start upd_o"}, upd == 1'b1, upd, 1);
      for (int p = 0; p < P; p++) begin
         vld = 1'b0;
         if (p == pa) begin
            mode = nm[0];
            if (va >= 0) begin smp = 10'(va); vld = 1'b1; pend_l = va; end
         end
         if (p == pb && vb >= 0) begin smp = 10'(vb); vld = 1'b1; pend_l = vb; end
         if (pwm !== exp_bit(cur_m, cur_l, p)) begin
            if (first < 0) begin first = p; fa = pwm; fe = exp_bit(cur_m, cur_l, p); end
            bad++;
         end
         tick();
      end
      vld = 1'b0;
      checks++;
      if (bad != 0) begin
         fails++;
         $display("FAIL %s mode=%0d lvl=%0d pos=%0d actual=%0d expected=%0d mismatches=%0d",
                  tag, cur_m, cur_l, first, fa, fe, bad);
      end
      cur_m = mode;
      cur_l = pend_l;
   endtask

   task automatic test_reset();
      check("R9 upd_o after reset", upd == 1'b1, upd, 1);
      check("R9 pwm_o after reset", pwm == 1'b0, pwm, 0);
      run_period("R9 reset period edge level 0", 0, 13, -1, -1, 0);
   endtask

   task automatic test_edge();
      run_period("R2 edge L13", 0, 200, -1, -1, 0);
      run_period("R2 edge L200", 0, 1, -1, -1, 0);
      run_period("R2 edge L1", 0, 511, -1, -1, 0);
      run_period("R2 edge L511", 0, 13, -1, -1, 1);
   endtask

   task automatic test_sym();
      run_period("R3 sym L13", 0, 200, -1, -1, 1);
      run_period("R3 sym L200", 0, 1, -1, -1, 1);
      run_period("R3 sym L1", 0, 511, -1, -1, 1);
      run_period("R3 sym L511", 0, 256, -1, -1, 1);
      run_period("R3 sym L256", 0, 0, -1, -1, 1);
   endtask

   task automatic test_limits();
      run_period("R4 sym L0", 0, 512, -1, -1, 1);
      run_period("R4 sym L512", 0, 1000, -1, -1, 1);
      run_period("R4 sym L1000 saturates", 0, 0, -1, -1, 0);
      run_period("R4 edge L0", 0, 512, -1, -1, 0);
      run_period("R4 edge L512", 0, 1000, -1, -1, 0);
   endtask

   task automatic test_buffering();
      // R5: strobe mid-period while saturated level is active
      run_period("R4 R5 edge L1000 with mid strobe", 100, 77, -1, -1, 0);
      // R6: strobe in the very last cycle
      run_period("R5 edge L77 with last-cycle strobe", P - 1, 300, -1, -1, 0);
      // R7: mode flips mid-period, no new sample
      run_period("R6 edge L300 with mid mode flip", 200, -1, -1, -1, 1);
      // R8: two strobes in one period
      run_period("R7 sym L300 after flip, two strobes", 10, 40, 400, 90, 1);
      run_period("R8 sym last strobe wins L90", -1, -1, -1, -1, 1);
      run_period("R8 sym level repeats L90", -1, -1, -1, -1, 1);
   endtask

   task automatic test_period_len();
      int n = 1;
      check("R1 upd_o at bottom", upd == 1'b1, upd, 1);
      tick();
      check("R1 upd_o one cycle", upd == 1'b0, upd, 0);
      while (upd == 1'b0 && n < 2 * P) begin
         tick();
         n++;
      end
      check("R1 period length", n == P, n, P);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      tick();
      tick();
      tick();
      rst_n = 1'b1;
      test_reset();
      test_edge();
      test_sym();
      test_limits();
      test_buffering();
      test_period_len();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule